// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the receiving end of a three-wire serial write port for a four-channel, 8-bit converter. It runs on a fast system clock. The serial clock, the data line, the frame strobe and the update strobe are all asynchronous to that clock, so the block oversamples each one through a synchronizer and acts on their falling edges. Command bits are shifted in on the falling edges of the serial clock. A falling edge on the frame strobe ends the frame. The block then checks the frame length and either stores the command or reports it as short.

Each channel has two registers. The input register holds the last code and gain written to that channel. The output register holds the code and gain the analog stage uses. The level of the update strobe at the moment the frame strobe falls decides what happens next. If the update strobe is low, the addressed output register changes at once. If it is high, the new value waits in the input register, and a later falling edge of the update strobe moves all four input registers to the outputs in the same cycle.

The outputs are the four codes, the four gain bits and a one-cycle error pulse for short frames.

Top module: `qdac_cmd_rx`

## Requirements
- R1: Each falling edge of `ser_clk_i` captures one bit from `ser_data_i`. Bits arrive most significant first.
- R2: A frame is 11 bits. The first two bits are the channel number (0 to 3 selects A to D), the third bit is the gain, and the last eight bits are the code. Channel n appears on `code_o[8n+7:8n]` and on `gain_o[n]`.
- R3: The gain bit is stored as received: 0 means a gain of one and 1 means a gain of two.
- R4: If more than 11 bits arrive before the frame strobe falls, only the 11 most recent bits are used.
- R5: If the frame strobe falls after fewer than 11 bits, `frame_err_o` is high for exactly one system clock cycle and no input or output register changes.
- R6: If `ldac_i` is low when the frame strobe falls on a valid frame, the addressed channel's output takes the new code and gain, and the other three outputs stay as they were.
- R7: If `ldac_i` is high when the frame strobe falls on a valid frame, no output changes. The value is held in the addressed channel's input register.
- R8: A falling edge of `ldac_i` copies all four input registers into the output registers in the same cycle.
- R9: The bit count and the shift register are cleared after every falling edge of the frame strobe, whether the frame was valid or short. Bits from an earlier frame never complete a later one.
- R10: After a synchronous reset, every code is 0, every gain bit is 0 and `frame_err_o` is low.
- R11: When a serial clock fall and a frame strobe fall are seen in the same system clock cycle, the bit is shifted in first and counts toward the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Asynchronous serial bit clock; bits are taken on its falling edge |
| ser_data_i | input | 1 | Asynchronous serial data |
| load_i | input | 1 | Asynchronous frame strobe; its falling edge ends a frame |
| ldac_i | input | 1 | Asynchronous update strobe; its level selects the update mode and its falling edge commits all channels |
| code_o | output | 32 | Output-register codes, channel n in bits 8n+7:8n |
| gain_o | output | 4 | Output-register gain bits, channel n in bit n |
| frame_err_o | output | 1 | One-cycle pulse when a short frame is rejected |

## Verification
The bench sends a frame with extra leading bits, to catch a design that takes the first 11 bits or that rejects long frames. It sends two short frames in a row: one of 7 bits, then one of 4 bits. A design that forgets to clear the counter would add the two together and accept the second as valid. The bench writes channels while the update strobe is high, to catch a design that updates the outputs early or copies only the last channel written when the strobe falls. It also drives the serial clock fall and the frame strobe fall together, to catch a design that handles the frame edge first and loses the final bit.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Increment a counter and hold it at the limit.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True when the counter shows that a complete frame was shifted in.
  function automatic logic frame_full(input int unsigned cnt, input int unsigned frame_w);
    return cnt == frame_w;
  endfunction
endpackage

// File: rtl/qdac_sync_fall.sv
module qdac_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  // The extra flop beyond the synchronizer keeps the previous level for edge detection.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_i};
  end

  assign level_o = chain[STAGES-1];
  assign fall_o  = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/qdac_frame_shift.sv
module qdac_frame_shift #(
  parameter int unsigned FRAME_W = 11,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_stb,
  input  logic               bit_val,
  input  logic               load_stb,
  output logic [FRAME_W-1:0] frame_o,
  output logic               wr_stb_o,
  output logic               err_stb_o,
  output logic               err_q_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [FRAME_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;

  // A bit strobe in the same cycle as the load strobe is shifted in first.
  always_comb begin
    sh_nxt  = sh_q;
    cnt_nxt = cnt_q;
    if (bit_stb) begin
      sh_nxt  = {sh_q[FRAME_W-2:0], bit_val};
      cnt_nxt = CNT_W'(qdac_pkg::sat_inc(int'(cnt_q), FRAME_W));
    end
  end

  assign frame_o   = sh_nxt;
  assign wr_stb_o  = load_stb &&  qdac_pkg::frame_full(int'(cnt_nxt), FRAME_W);
  assign err_stb_o = load_stb && !qdac_pkg::frame_full(int'(cnt_nxt), FRAME_W);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load_stb) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q_o <= 1'b0;
    else     err_q_o <= err_stb_o;
  end
endmodule

// File: rtl/qdac_reg_bank.sv
module qdac_reg_bank #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned NCH   = 1 << SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic                  wr_gain,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic                  wr_now,
  input  logic                  commit_all,
  output logic [NCH*CODE_W-1:0] out_code,
  output logic [NCH-1:0]        out_gain,
  output logic [NCH*CODE_W-1:0] in_code,
  output logic [NCH-1:0]        in_gain
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] in_c_q, out_c_q;
    logic              in_g_q, out_g_q;

    assign hit = wr_stb && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        in_c_q  <= '0;
        in_g_q  <= 1'b0;
        out_c_q <= '0;
        out_g_q <= 1'b0;
      end else begin
        if (hit) begin
          in_c_q <= wr_code;
          in_g_q <= wr_gain;
        end
        // An immediate write to this channel takes precedence over a commit of the old input value.
        if (hit && wr_now) begin
          out_c_q <= wr_code;
          out_g_q <= wr_gain;
        end else if (commit_all) begin
          out_c_q <= in_c_q;
          out_g_q <= in_g_q;
        end
      end
    end

    assign out_code[g*CODE_W +: CODE_W] = out_c_q;
    assign out_gain[g]                  = out_g_q;
    assign in_code[g*CODE_W +: CODE_W]  = in_c_q;
    assign in_gain[g]                   = in_g_q;
  end
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx #(
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NCH     = 1 << SEL_W,
  localparam int unsigned FRAME_W = SEL_W + 1 + CODE_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk_i,
  input  logic                  ser_data_i,
  input  logic                  load_i,
  input  logic                  ldac_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        gain_o,
  output logic                  frame_err_o
);
  // Index of each asynchronous input in the synchronizer vector.
  localparam int unsigned IX_SCLK = 0, IX_DATA = 1, IX_LOAD = 2, IX_LDAC = 3, N_IN = 4;

  logic [N_IN-1:0] raw_in, lvl, fall;
  assign raw_in = {ldac_i, load_i, ser_data_i, ser_clk_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    qdac_sync_fall #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .async_i(raw_in[i]), .level_o(lvl[i]), .fall_o(fall[i])
    );
  end

  // Named event wires, also used by the checker.
  logic clk_fall, load_fall, ldac_fall;
  assign clk_fall  = fall[IX_SCLK];
  assign load_fall = fall[IX_LOAD];
  assign ldac_fall = fall[IX_LDAC];

  logic [FRAME_W-1:0] frame;
  logic               wr_stb, err_stb;
  logic [CNT_W-1:0]   bit_cnt;

  qdac_frame_shift #(.FRAME_W(FRAME_W)) shift_i (
    .clk(clk), .rst(rst), .bit_stb(clk_fall), .bit_val(lvl[IX_DATA]),
    .load_stb(load_fall), .frame_o(frame), .wr_stb_o(wr_stb),
    .err_stb_o(err_stb), .err_q_o(frame_err_o), .cnt_o(bit_cnt)
  );

  // Frame layout: select bits first (most significant), then gain, then code.
  logic [SEL_W-1:0]  f_sel;
  logic              f_gain;
  logic [CODE_W-1:0] f_code;
  assign f_sel  = frame[FRAME_W-1 -: SEL_W];
  assign f_gain = frame[CODE_W];
  assign f_code = frame[CODE_W-1:0];

  logic [NCH*CODE_W-1:0] in_code;
  logic [NCH-1:0]        in_gain;

  qdac_reg_bank #(.SEL_W(SEL_W), .CODE_W(CODE_W)) bank_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sel(f_sel), .wr_gain(f_gain),
    .wr_code(f_code), .wr_now(!lvl[IX_LDAC]), .commit_all(ldac_fall),
    .out_code(code_o), .out_gain(gain_o), .in_code(in_code), .in_gain(in_gain)
  );
endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk #(
  parameter int unsigned NCH     = 4,
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned CNT_W   = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  load_fall,
  input logic                  ldac_fall,
  input logic                  wr_stb,
  input logic                  err_stb,
  input logic [CNT_W-1:0]      bit_cnt,
  input logic [NCH*CODE_W-1:0] code_o,
  input logic [NCH-1:0]        gain_o,
  input logic [NCH*CODE_W-1:0] in_code,
  input logic [NCH-1:0]        in_gain,
  input logic                  frame_err_o
);
  // R5
  err_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> $past(load_fall));
  // R5
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (err_stb && !ldac_fall) |=> ($stable(code_o) && $stable(gain_o) && $stable(in_code) && $stable(in_gain)));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, err_stb}));
  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    load_fall |=> (bit_cnt == '0));
  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W));
  // R8
  commit_all_chk: assert property (@(posedge clk) disable iff (rst)
    (ldac_fall && !wr_stb) |=> (code_o == in_code && gain_o == in_gain));
  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && !ldac_fall) |=> ($stable(code_o) && $stable(gain_o)));
endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk #(
  .NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .load_fall(load_fall), .ldac_fall(ldac_fall),
  .wr_stb(wr_stb), .err_stb(err_stb), .bit_cnt(bit_cnt), .code_o(code_o),
  .gain_o(gain_o), .in_code(in_code), .in_gain(in_gain), .frame_err_o(frame_err_o)
);

// File: tb/qdac_cmd_rx_tb.sv
module qdac_cmd_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;  // system cycles per serial phase

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b1, ser_data = 1'b0, load = 1'b1, ldac = 1'b0;
  logic [31:0] code_o;
  logic [3:0]  gain_o;
  logic        frame_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_cmd_rx dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .load_i(load), .ldac_i(ldac), .code_o(code_o), .gain_o(gain_o),
    .frame_err_o(frame_err_o)
  );

  int checks = 0, fails = 0, err_pulses = 0;
  logic [7:0] m_in_c[4], m_out_c[4];
  logic       m_in_g[4], m_out_g[4];

  always @(negedge clk) if (!rst && frame_err_o) err_pulses++;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    for (int c = 0; c < 4; c++) begin
      check(req, {24'd0, code_o[c*8 +: 8]}, {24'd0, m_out_c[c]});
      check(req, {31'd0, gain_o[c]}, {31'd0, m_out_g[c]});
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;  wait_cyc(PH);
    ser_clk  = 1'b0; wait_cyc(PH);
    ser_clk  = 1'b1; wait_cyc(PH);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_load();
    load = 1'b0; wait_cyc(2*PH);
    load = 1'b1; wait_cyc(PH);
  endtask

  // Model of a valid frame landing; ldac level taken at the load edge.
  task automatic model_write(input int sel, input logic g, input logic [7:0] c);
    m_in_c[sel] = c; m_in_g[sel] = g;
    if (!ldac) begin m_out_c[sel] = c; m_out_g[sel] = g; end
  endtask

  task automatic write_frame(input int sel, input logic g, input logic [7:0] c);
    send_bits({21'd0, 2'(sel), g, c}, 11);
    pulse_load();
    model_write(sel, g, c);
  endtask

  // R10
  task automatic t_reset();
    for (int c = 0; c < 4; c++) begin
      m_in_c[c] = '0; m_out_c[c] = '0; m_in_g[c] = 1'b0; m_out_g[c] = 1'b0;
    end
    check("R10 err", {31'd0, frame_err_o}, 32'd0);
    check_outputs("R10");
  endtask

  // R1 R2 R3 R6
  task automatic t_immediate();
    ldac = 1'b0;
    write_frame(2, 1'b1, 8'hA5);
    check_outputs("R6/R1/R2");
    write_frame(0, 1'b0, 8'h01);
    check_outputs("R3/R6");
    write_frame(3, 1'b1, 8'h80);
    check_outputs("R2 ch3");
  endtask

  // R7 R8
  task automatic t_deferred();
    ldac = 1'b1; wait_cyc(2*PH);
    write_frame(1, 1'b1, 8'h3C);
    write_frame(3, 1'b0, 8'h7E);
    write_frame(0, 1'b1, 8'hC3);
    check_outputs("R7 held");
    ldac = 1'b0; wait_cyc(2*PH);
    for (int c = 0; c < 4; c++) begin m_out_c[c] = m_in_c[c]; m_out_g[c] = m_in_g[c]; end
    check_outputs("R8 commit");
  endtask

  // R4
  task automatic t_long();
    send_bits(32'b1011, 4);
    write_frame(1, 1'b0, 8'h5A);
    check_outputs("R4 last 11");
  endtask

  // R5 R9
  task automatic t_short();
    int e0;
    e0 = err_pulses;
    send_bits(32'h55, 7);
    pulse_load();
    check("R5 err pulse", err_pulses, e0 + 1);
    check_outputs("R5 no change");
    send_bits(32'hF, 4);
    pulse_load();
    check("R9 cleared count", err_pulses, e0 + 2);
    check_outputs("R9 no change");
    write_frame(2, 1'b0, 8'h11);
    check("R9 valid no err", err_pulses, e0 + 2);
    check_outputs("R9 valid after short");
  endtask

  // R11
  task automatic t_coincident();
    logic [10:0] f;
    f = {2'd3, 1'b0, 8'h99};
    send_bits({21'd0, f[10:1]}, 10);
    ser_data = f[0]; wait_cyc(PH);
    ser_clk = 1'b0; load = 1'b0; wait_cyc(2*PH);
    ser_clk = 1'b1; load = 1'b1; wait_cyc(PH);
    model_write(3, 1'b0, 8'h99);
    check_outputs("R11 same-cycle edges");
  endtask

  bit done = 1'b0;
  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(4);
    t_reset();
    t_immediate();
    t_deferred();
    t_long();
    t_short();
    t_coincident();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule